// File: doc/BRIEF.md
# Vectored Interrupt Controller with Masking

This controller sits beside a small in-order processor core and decides when the core leaves its normal instruction stream for a single interrupt handler. It has 32 request lines. Each line can be driven from an external input. Three of them can also be raised from inside the core: a timer expiry, a breakpoint or illegal instruction, and a misaligned memory access. Requests are latched as pending. Two masks filter them: a mask that software rewrites at run time, and a fixed build-time mask that can never be overridden.

When an enabled request is pending and no handler is running, the controller offers a redirect to a fixed handler address. It uses a valid/ready pair. `redir_valid` never depends on `redir_ready`, and the core raises `redir_ready` only at an instruction boundary, where it also presents the return address. The handshake completes in any cycle where both are high; `redir_valid` may fall without a transfer if the core is not ready and the condition goes away. On transfer, the controller stores the return address and the set of serviced requests in holding registers. It raises an end-of-interrupt line for each serviced request until the core signals a return. Two scratch holding registers are free for the handler. A wait request reports when something enabled is pending. A fault whose request line is disabled halts the core instead of pending.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A 1 on `irq_in[n]` at a clock edge sets pending bit n, which stays set until delivered; if a bit is delivered at the same edge where its source is high, it stays pending.
- R2: After reset the runtime mask reads all ones (1 = disabled), `redir_valid`, `eoi` and `halt` are 0, and `boot_pc` equals the RESET_ADDR parameter.
- R3: A request whose bit is 1 in the FIXED_MASK parameter never becomes pending, never raises `redir_valid` or `wait_done`, and never appears on `eoi`, whatever the runtime mask holds.
- R4: `mask_old` shows the current runtime mask; with `mask_wr_en` high, `mask_wr_data` replaces it at the next edge.
- R5: `redir_valid` is high exactly when not halted, no handler is active, and some pending bit is enabled in both masks; `redir_pc` equals HANDLER_ADDR.
- R6: On a transfer (`redir_valid` and `redir_ready`), holding register 0 takes `ret_addr`, holding register 1 takes the enabled pending bits (zero-extended), and only those pending bits clear; masked pending bits remain.
- R7: From the cycle after a transfer until a return, `eoi` equals the serviced bit set.
- R8: While a handler is active `redir_valid` is 0; requests that arrive then stay pending and are offered after the return.
- R9: `ret_req` while a handler is active drops `eoi` to 0 and ends the handler at the next edge; `ret_pc` always shows holding register 0; `ret_req` with no handler active has no effect.
- R10: `q_wr_en` writes `q_wr_data` to holding register `q_wr_sel` (0 return, 1 serviced bits, 2 and 3 scratch); `q_rd_data` shows register `q_rd_sel`; a transfer's write to register 0 or 1 wins over a software write in the same cycle.
- R11: A one-cycle pulse on `tmr_pulse` pends bit 0, on `fault_illegal` bit 1, and on `fault_misalign` bit 2; a fault pends only if its bit is enabled.
- R12: A fault whose bit is disabled in either mask sets `halt`, which stays high until reset, holds `redir_valid` at 0, and leaves that pending bit clear.
- R13: `wait_bits` shows the enabled pending bits, and `wait_done` is high exactly when `wait_req` is high and `wait_bits` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | External request lines |
| tmr_pulse | input | 1 | Timer expiry pulse, request 0 |
| fault_illegal | input | 1 | Breakpoint or illegal instruction pulse, request 1 |
| fault_misalign | input | 1 | Misaligned access pulse, request 2 |
| redir_valid | output | 1 | Redirect to handler offered |
| redir_ready | input | 1 | Core at an instruction boundary, accepts redirect |
| redir_pc | output | XLEN | Handler address |
| ret_addr | input | XLEN | Return address captured on transfer |
| ret_req | input | 1 | Return from handler |
| ret_pc | output | XLEN | Address to resume at on return |
| boot_pc | output | XLEN | Program start address |
| mask_wr_en | input | 1 | Runtime mask write strobe |
| mask_wr_data | input | NUM_IRQ | New runtime mask |
| mask_old | output | NUM_IRQ | Current runtime mask |
| q_wr_en | input | 1 | Holding register write strobe |
| q_wr_sel | input | 2 | Holding register write index |
| q_wr_data | input | XLEN | Holding register write data |
| q_rd_sel | input | 2 | Holding register read index |
| q_rd_data | output | XLEN | Holding register read data |
| wait_req | input | 1 | Core stalled waiting for a request |
| wait_done | output | 1 | Wait may finish |
| wait_bits | output | NUM_IRQ | Enabled pending bits |
| eoi | output | NUM_IRQ | Per-request end-of-interrupt lines |
| halt | output | 1 | Core must halt |

## Verification
A walking single request is swept over all 32 lines with the runtime mask open. This separates correct per-line routing into the serviced set and the `eoi` lines from shifted or merged bits, and it shows that the fixed-masked line stays silent. Wide multi-bit patterns against a partial runtime mask show that entry takes the enabled subset and leaves the masked remainder pending. Requests raised during a running handler, and a source held high across its own delivery, expose wrong nesting and clear-versus-set priority. Internal fault pulses under open and closed masks separate pending from halting.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Holding register indices; the core's get/set operations decode these.
  typedef enum logic [1:0] {
    QSEL_RET  = 2'd0,
    QSEL_BITS = 2'd1,
    QSEL_TMP0 = 2'd2,
    QSEL_TMP1 = 2'd3
  } qsel_e;

  localparam int unsigned QREG_COUNT = 4;

  // Request numbers of the internal sources
  localparam int unsigned SRC_TIMER    = 0;
  localparam int unsigned SRC_ILLEGAL  = 1;
  localparam int unsigned SRC_MISALIGN = 2;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned           NUM_IRQ    = 32,
  parameter logic [NUM_IRQ-1:0]    FIXED_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_vec,
  input  logic [NUM_IRQ-1:0] clr_vec,
  output logic [NUM_IRQ-1:0] pend
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    if (FIXED_MASK[i]) begin : g_off
      // permanently disabled line: no storage at all
      assign pend[i] = 1'b0;
    end else begin : g_on
      logic pq;
      always_ff @(posedge clk) begin
        if (!rst_n)          pq <= 1'b0;
        else if (set_vec[i]) pq <= 1'b1;   // a new request beats delivery
        else if (clr_vec[i]) pq <= 1'b0;
      end
      assign pend[i] = pq;
    end
  end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
  import irqc_pkg::*;
#(
  parameter int unsigned        NUM_IRQ    = 32,
  parameter logic [NUM_IRQ-1:0] FIXED_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic               tmr_pulse,
  input  logic               fault_illegal,
  input  logic               fault_misalign,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic [NUM_IRQ-1:0] mask_eff,
  output logic [NUM_IRQ-1:0] int_set,
  output logic               halt
);
  logic halt_q;
  logic ill_blocked, mis_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= wr_data;
  end

  assign mask_eff    = mask_q | FIXED_MASK;
  assign ill_blocked = fault_illegal  & mask_eff[SRC_ILLEGAL];
  assign mis_blocked = fault_misalign & mask_eff[SRC_MISALIGN];

  always_comb begin
    int_set = '0;
    int_set[SRC_TIMER]    = tmr_pulse;
    int_set[SRC_ILLEGAL]  = fault_illegal  & ~mask_eff[SRC_ILLEGAL];
    int_set[SRC_MISALIGN] = fault_misalign & ~mask_eff[SRC_MISALIGN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_q | ill_blocked | mis_blocked;
  end

  assign halt = halt_q;
endmodule

// File: rtl/irqc_hold.sv
module irqc_hold
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned XLEN    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [NUM_IRQ-1:0] take_bits,
  input  logic [XLEN-1:0]    take_addr,
  input  logic               ret,
  input  logic               q_wr_en,
  input  logic [1:0]         q_wr_sel,
  input  logic [XLEN-1:0]    q_wr_data,
  input  logic [1:0]         q_rd_sel,
  output logic [XLEN-1:0]    q_rd_data,
  output logic [XLEN-1:0]    q_ret,
  output logic               active,
  output logic [NUM_IRQ-1:0] eoi
);
  logic [XLEN-1:0] qr [QREG_COUNT];

  for (genvar i = 0; i < QREG_COUNT; i++) begin : g_q
    localparam qsel_e IDX = qsel_e'(i);
    logic [XLEN-1:0] capt;
    logic            capt_en;
    if (IDX == QSEL_RET) begin : g_ret
      assign capt_en = take;
      assign capt    = take_addr;
    end else if (IDX == QSEL_BITS) begin : g_bits
      assign capt_en = take;
      assign capt    = XLEN'(take_bits);
    end else begin : g_tmp
      assign capt_en = 1'b0;
      assign capt    = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                  qr[i] <= '0;
      else if (capt_en)                            qr[i] <= capt;
      else if (q_wr_en && q_wr_sel == 2'(i))       qr[i] <= q_wr_data;
    end
  end

  assign q_rd_data = qr[q_rd_sel];
  assign q_ret     = qr[QSEL_RET];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      eoi    <= '0;
    end else if (take) begin
      active <= 1'b1;
      eoi    <= take_bits;
    end else if (ret) begin
      active <= 1'b0;
      eoi    <= '0;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned        NUM_IRQ      = 32,
  parameter int unsigned        XLEN         = 32,
  parameter logic [NUM_IRQ-1:0] FIXED_MASK   = '0,
  parameter logic [XLEN-1:0]    HANDLER_ADDR = 32'h0000_0010,
  parameter logic [XLEN-1:0]    RESET_ADDR   = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               tmr_pulse,
  input  logic               fault_illegal,
  input  logic               fault_misalign,
  output logic               redir_valid,
  input  logic               redir_ready,
  output logic [XLEN-1:0]    redir_pc,
  input  logic [XLEN-1:0]    ret_addr,
  input  logic               ret_req,
  output logic [XLEN-1:0]    ret_pc,
  output logic [XLEN-1:0]    boot_pc,
  input  logic               mask_wr_en,
  input  logic [NUM_IRQ-1:0] mask_wr_data,
  output logic [NUM_IRQ-1:0] mask_old,
  input  logic               q_wr_en,
  input  logic [1:0]         q_wr_sel,
  input  logic [XLEN-1:0]    q_wr_data,
  input  logic [1:0]         q_rd_sel,
  output logic [XLEN-1:0]    q_rd_data,
  input  logic               wait_req,
  output logic               wait_done,
  output logic [NUM_IRQ-1:0] wait_bits,
  output logic [NUM_IRQ-1:0] eoi,
  output logic               halt
);
  logic [NUM_IRQ-1:0] mask_q, mask_eff, int_set, pend, en_pend, set_vec, clr_vec;
  logic               active, take, ret, any_en;

  irqc_mask #(.NUM_IRQ(NUM_IRQ), .FIXED_MASK(FIXED_MASK)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en), .wr_data(mask_wr_data),
    .tmr_pulse(tmr_pulse), .fault_illegal(fault_illegal),
    .fault_misalign(fault_misalign), .mask_q(mask_q), .mask_eff(mask_eff),
    .int_set(int_set), .halt(halt)
  );

  assign set_vec = irq_in | int_set;
  assign en_pend = pend & ~mask_eff;
  assign any_en  = |en_pend;
  assign clr_vec = take ? en_pend : '0;

  irqc_pending #(.NUM_IRQ(NUM_IRQ), .FIXED_MASK(FIXED_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  assign redir_valid = any_en & ~active & ~halt;
  assign take        = redir_valid & redir_ready;
  assign ret         = ret_req & active;

  irqc_hold #(.NUM_IRQ(NUM_IRQ), .XLEN(XLEN)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take), .take_bits(en_pend),
    .take_addr(ret_addr), .ret(ret), .q_wr_en(q_wr_en), .q_wr_sel(q_wr_sel),
    .q_wr_data(q_wr_data), .q_rd_sel(q_rd_sel), .q_rd_data(q_rd_data),
    .q_ret(ret_pc), .active(active), .eoi(eoi)
  );

  assign redir_pc  = HANDLER_ADDR;
  assign boot_pc   = RESET_ADDR;
  assign mask_old  = mask_q;
  assign wait_bits = en_pend;
  assign wait_done = wait_req & any_en;
endmodule

// File: rtl/irqc_check.sv
module irqc_check #(
  parameter int unsigned        NUM_IRQ    = 32,
  parameter logic [NUM_IRQ-1:0] FIXED_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               redir_valid,
  input logic               redir_ready,
  input logic               ret_req,
  input logic               active,
  input logic [NUM_IRQ-1:0] en_pend,
  input logic [NUM_IRQ-1:0] eoi,
  input logic               halt,
  input logic               mask_wr_en,
  input logic [NUM_IRQ-1:0] mask_wr_data,
  input logic [NUM_IRQ-1:0] mask_old,
  input logic               wait_req,
  input logic               wait_done
);
  assert_fixed_never_eoi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi & FIXED_MASK) == '0);

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_old == $past(mask_wr_data));

  assert_entry_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_ready) |=> (active && eoi == $past(en_pend)));

  assert_no_nesting_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !redir_valid);

  assert_return_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && active && !(redir_valid && redir_ready)) |=> (!active && eoi == '0));

  assert_idle_ret_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(redir_valid && redir_ready)) |=> eoi == '0);

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_halt_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !redir_valid);

  assert_wait_needs_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> (wait_req && en_pend != '0));
endmodule

bind vec_irq_ctrl irqc_check #(.NUM_IRQ(NUM_IRQ), .FIXED_MASK(FIXED_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_ready(redir_ready),
  .ret_req(ret_req), .active(active), .en_pend(en_pend), .eoi(eoi), .halt(halt),
  .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_old(mask_old),
  .wait_req(wait_req), .wait_done(wait_done)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam logic [31:0] FIXED = 32'h8000_0000;
  localparam logic [31:0] HADDR = 32'h0000_0010;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_in = '0, ret_addr = '0, mask_wr_data = '0, q_wr_data = '0;
  logic        tmr_pulse = 0, fault_illegal = 0, fault_misalign = 0;
  logic        redir_ready = 0, ret_req = 0, mask_wr_en = 0, q_wr_en = 0, wait_req = 0;
  logic [1:0]  q_wr_sel = '0, q_rd_sel = '0;
  logic        redir_valid, wait_done, halt;
  logic [31:0] redir_pc, ret_pc, boot_pc, mask_old, q_rd_data, wait_bits, eoi;
  int checks = 0, fails = 0;
  bit done = 0;

  vec_irq_ctrl #(.FIXED_MASK(FIXED), .HANDLER_ADDR(HADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tmr_pulse(tmr_pulse),
    .fault_illegal(fault_illegal), .fault_misalign(fault_misalign),
    .redir_valid(redir_valid), .redir_ready(redir_ready), .redir_pc(redir_pc),
    .ret_addr(ret_addr), .ret_req(ret_req), .ret_pc(ret_pc), .boot_pc(boot_pc),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_old(mask_old),
    .q_wr_en(q_wr_en), .q_wr_sel(q_wr_sel), .q_wr_data(q_wr_data),
    .q_rd_sel(q_rd_sel), .q_rd_data(q_rd_data), .wait_req(wait_req),
    .wait_done(wait_done), .wait_bits(wait_bits), .eoi(eoi), .halt(halt)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse(input logic [31:0] bits);
    irq_in = bits; tick(); irq_in = '0; settle();
  endtask

  task automatic enter(input logic [31:0] addr);
    redir_ready = 1; ret_addr = addr; tick(); redir_ready = 0; settle();
  endtask

  task automatic leave();
    ret_req = 1; tick(); ret_req = 0; settle();
  endtask

  task automatic set_mask(input logic [31:0] m);
    mask_wr_en = 1; mask_wr_data = m; tick(); mask_wr_en = 0; settle();
  endtask

  task automatic readq(input logic [1:0] sel);
    q_rd_sel = sel; settle();
  endtask

  initial begin
    repeat (3) tick();
    chk("R2 mask reset", mask_old, 32'hFFFF_FFFF);
    chk("R2 redir idle", 32'(redir_valid), 0);
    chk("R2 eoi idle", eoi, 0);
    chk("R2 halt idle", 32'(halt), 0);
    rst_n = 1; tick();
    chk("R2 boot pc", boot_pc, 32'h0);

    // request while everything is masked
    pulse(32'h20);
    chk("R5 masked no redirect", 32'(redir_valid), 0);
    wait_req = 1; settle();
    chk("R13 masked no wake", 32'(wait_done), 0);
    wait_req = 0;

    mask_wr_en = 1; mask_wr_data = '0; settle();
    chk("R4 old mask visible", mask_old, 32'hFFFF_FFFF);
    tick(); mask_wr_en = 0; settle();
    chk("R4 mask replaced", mask_old, 32'h0);
    chk("R5 redirect offered", 32'(redir_valid), 1);
    chk("R5 handler pc", redir_pc, HADDR);
    wait_req = 1; settle();
    chk("R13 wake", 32'(wait_done), 1);
    chk("R13 wait bits", wait_bits, 32'h20);
    wait_req = 0;

    enter(32'h1234);
    readq(2'd0); chk("R6 return addr", q_rd_data, 32'h1234);
    readq(2'd1); chk("R6 serviced bits", q_rd_data, 32'h20);
    chk("R7 eoi on entry", eoi, 32'h20);
    chk("R9 ret pc", ret_pc, 32'h1234);
    pulse(32'h80);
    chk("R8 no nesting", 32'(redir_valid), 0);
    chk("R7 eoi held", eoi, 32'h20);
    leave();
    chk("R9 eoi dropped", eoi, 0);
    chk("R8 queued offered", 32'(redir_valid), 1);
    enter(32'h2000);
    readq(2'd1); chk("R8 queued bits", q_rd_data, 32'h80);
    leave();

    // walking request over every line
    for (int n = 0; n < 32; n++) begin
      pulse(32'h1 << n);
      if (FIXED[n]) begin
        chk("R3 fixed line silent", 32'(redir_valid), 0);
        chk("R3 fixed line not pending", wait_bits, 0);
      end else begin
        chk("R5 walk offered", 32'(redir_valid), 1);
        enter(32'(n * 4));
        readq(2'd1); chk("R6 walk bits", q_rd_data, 32'h1 << n);
        readq(2'd0); chk("R6 walk addr", q_rd_data, 32'(n * 4));
        chk("R7 walk eoi", eoi, 32'h1 << n);
        leave();
        chk("R9 walk return", eoi, 0);
      end
    end
    set_mask(32'h0);
    chk("R3 fixed survives open mask", wait_bits, 0);

    // partial mask against a wide pattern
    set_mask(32'h0000_00F0);
    pulse(32'h8000_0FFF);
    enter(32'h40);
    readq(2'd1); chk("R6 enabled subset", q_rd_data, 32'h0000_0F0F);
    leave();
    chk("R6 masked kept, not offered", 32'(redir_valid), 0);
    set_mask(32'h0);
    chk("R6 masked remainder", wait_bits, 32'h0000_00F0);
    enter(32'h44);
    readq(2'd1); chk("R6 remainder delivered", q_rd_data, 32'h0000_00F0);
    leave();

    // source still high at its own delivery edge
    pulse(32'h8);
    irq_in = 32'h8; enter(32'h50); irq_in = '0; settle();
    readq(2'd1); chk("R1 delivered", q_rd_data, 32'h8);
    leave();
    chk("R1 set beats clear", wait_bits, 32'h8);
    enter(32'h54); leave();
    chk("R1 cleared after delivery", wait_bits, 0);

    // holding register access
    q_wr_en = 1; q_wr_sel = 2'd2; q_wr_data = 32'hAAAA_5555; tick();
    q_wr_sel = 2'd3; q_wr_data = 32'h1357_9BDF; tick(); q_wr_en = 0; settle();
    readq(2'd2); chk("R10 scratch a", q_rd_data, 32'hAAAA_5555);
    readq(2'd3); chk("R10 scratch b", q_rd_data, 32'h1357_9BDF);
    pulse(32'h100);
    q_wr_en = 1; q_wr_sel = 2'd0; q_wr_data = 32'hDEAD_0000;
    enter(32'h60); q_wr_en = 0;
    readq(2'd0); chk("R10 capture beats write", q_rd_data, 32'h60);
    leave();
    ret_req = 1; tick(); ret_req = 0; settle();
    chk("R9 idle return ignored eoi", eoi, 0);
    chk("R9 idle return keeps q0", ret_pc, 32'h60);

    // internal sources
    tmr_pulse = 1; tick(); tmr_pulse = 0; settle();
    enter(32'h70); readq(2'd1); chk("R11 timer bit", q_rd_data, 32'h1); leave();
    fault_illegal = 1; tick(); fault_illegal = 0; settle();
    enter(32'h74); readq(2'd1); chk("R11 illegal bit", q_rd_data, 32'h2); leave();
    fault_misalign = 1; tick(); fault_misalign = 0; settle();
    enter(32'h78); readq(2'd1); chk("R11 misalign bit", q_rd_data, 32'h4); leave();
    chk("R12 no halt when enabled", 32'(halt), 0);

    // fault on a disabled line
    set_mask(32'h2);
    fault_illegal = 1; tick(); fault_illegal = 0; settle();
    chk("R12 halt raised", 32'(halt), 1);
    pulse(32'h10);
    chk("R12 halt blocks redirect", 32'(redir_valid), 0);
    set_mask(32'h0);
    chk("R12 fault not pending", wait_bits, 32'h10);
    repeat (3) tick();
    chk("R12 halt sticky", 32'(halt), 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule